// File: doc/BRIEF.md
# Sized Shifter with Carry Rotation

This block shifts one operand by a variable amount at a selectable operand width of 8, 16 or 32 bits. It has five operations: logical left, left with carry insertion, logical right, arithmetic right and right with carry insertion. For the two carry-insert operations, the incoming carry flag goes into the vacated bit next to the shifted data. This allows multi-word shifts, one word at a time.

The block takes the operand, a shift amount, an operation code, a size code and the current carry flag. It returns the shifted result and four flags: carry, overflow, negative and zero. All outputs are registered and appear one clock after the inputs that produce them.

The amount is masked to the operand width before use. An amount of zero passes the operand through and clears carry. Decoding and register writeback are left to the surrounding datapath.

Top module: `sized_shifter`

## Requirements
- R1: While rst_n is low, and until the first capture after reset, result_o, carry_o, ovf_o, neg_o and zero_o are all 0.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge (one cycle latency).
- R3: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. The effective amount n is amount_i masked to its low 3, 4 or 5 bits respectively.
- R4: When n is 0, the result is the operand truncated to the size and carry_o is 0, for every operation.
- R5: Op code 0 (and the unused codes 5 to 7) shifts left logically. For nonzero n, carry_o is operand bit (size - n).
- R6: Op code 1 shifts left like op 0. For nonzero n, it also places the incoming carry_i at result bit n - 1.
- R7: Op code 2 shifts right logically with zero fill. For nonzero n, carry_o is operand bit n - 1.
- R8: Op code 3 shifts right and fills the vacated top bits with the operand's sign bit at the selected size. Carry follows R7.
- R9: Op code 4 shifts right like op 2. For nonzero n, it also places carry_i at result bit (size - n). Carry follows R7.
- R10: ovf_o is always 0.
- R11: Result bits at and above the selected size are 0. neg_o is the result's top bit at the selected size, and zero_o is set exactly when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (see R5 to R9) |
| size_i | input | 2 | Operand size code (see R3) |
| value_i | input | 32 | Operand to shift |
| amount_i | input | 8 | Shift amount before masking |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted result, zero above the size |
| carry_o | output | 1 | Last bit shifted out |
| ovf_o | output | 1 | Overflow flag, always 0 |
| neg_o | output | 1 | Sign of the result at the selected size |
| zero_o | output | 1 | Result equals zero |

## Verification
The following are checked by assertions on every cycle after reset:
- the zero-amount pass-through;
- the clean upper bits above the size;
- the consistency of neg_o and zero_o with the registered result;
- the position of the inserted carry bit for both carry-insert operations;
- the always-clear overflow flag.

The exact shifted bit patterns, the carry value taken from the operand, the sign fill of the arithmetic shift and the masking of oversized amounts depend on operand data. These are shown only by the bench's directed scenarios, which compare against a bit-by-bit reference model.

// File: rtl/sized_shifter.sv
module sized_shifter #(
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [1:0]       size_i,
  input  logic [31:0]      value_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic             carry_i,
  output logic [31:0]      result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             neg_o,
  output logic             zero_o
);

  localparam logic [2:0] OP_SHLC = 3'd1;
  localparam logic [2:0] OP_SHR  = 3'd2;
  localparam logic [2:0] OP_SAR  = 3'd3;
  localparam logic [2:0] OP_SHRC = 3'd4;

  logic [5:0]  w;
  logic [31:0] mask;
  logic [4:0]  n;
  logic [5:0]  wn;
  logic [31:0] v;
  logic        sgn;
  logic        go_right;
  logic [31:0] r;
  logic        c;

  always_comb begin
    case (size_i)
      2'd0:    begin w = 6'd8;  mask = 32'h0000_00FF; n = {2'b00, amount_i[2:0]}; end
      2'd1:    begin w = 6'd16; mask = 32'h0000_FFFF; n = {1'b0, amount_i[3:0]}; end
      default: begin w = 6'd32; mask = 32'hFFFF_FFFF; n = amount_i[4:0]; end
    endcase
  end

  assign wn       = w - {1'b0, n};
  assign v        = value_i & mask;
  assign sgn      = |(v & (mask & ~(mask >> 1)));
  assign go_right = (op_i == OP_SHR) || (op_i == OP_SAR) || (op_i == OP_SHRC);

  always_comb begin
    r = '0;
    c = 1'b0;
    if (go_right) begin
      r = v >> n;
      if (n != '0) begin
        c = v[n - 5'd1];
        if (op_i == OP_SAR && sgn) r = r | (mask & ~(mask >> n));
        if (op_i == OP_SHRC) r = r | ({31'd0, carry_i} << wn[4:0]);
      end
    end else begin
      r = (v << n) & mask;
      if (n != '0) begin
        c = v[wn[4:0]];
        if (op_i == OP_SHLC) r = r | ({31'd0, carry_i} << (n - 5'd1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      neg_o    <= 1'b0;
      zero_o   <= 1'b0;
    end else begin
      result_o <= r;
      carry_o  <= c;
      neg_o    <= sgn_of_r;
      zero_o   <= (r == '0);
    end
  end

  logic sgn_of_r;
  assign sgn_of_r = |(r & (mask & ~(mask >> 1)));
  assign ovf_o    = 1'b0;

  // R4: zero amount passes the operand and clears carry
  a_r4_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(n) == '0) |-> (result_o == $past(v) && !carry_o));

  // R11: nothing above the selected size
  a_r11_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((result_o & ~$past(mask)) == '0));

  // R11: zero and negative flags agree with the registered result
  a_r11_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (zero_o == (result_o == '0)));

  a_r11_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (neg_o == |(result_o & ($past(mask) & ~($past(mask) >> 1)))));

  // R6: left carry insertion lands at bit n-1
  a_r6_shlc_insert: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == OP_SHLC && $past(n) != '0)
      |-> (result_o[$past(n) - 5'd1] == $past(carry_i)));

  // R9: right carry insertion lands at bit size-n
  a_r9_shrc_insert: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == OP_SHRC && $past(n) != '0)
      |-> (result_o[$past(wn[4:0])] == $past(carry_i)));

  // R10: overflow never raised
  always_comb a_r10_no_overflow: assert (ovf_o == 1'b0);

endmodule

// File: tb/sized_shifter_test.sv
`timescale 1ns/1ps
module sized_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] value_i = '0;
  logic [7:0]  amount_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o, ovf_o, neg_o, zero_o;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sized_shifter uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i), .value_i(value_i),
    .amount_i(amount_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o),
    .ovf_o(ovf_o), .neg_o(neg_o), .zero_o(zero_o)
  );

  function automatic int width_of(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  // bit-by-bit reference: returns {carry, result}
  function automatic logic [32:0] model(input logic [2:0] op, input logic [1:0] s,
                                        input logic [31:0] val, input logic [7:0] amt,
                                        input logic cin);
    int wd = width_of(s);
    int k = int'(amt) % wd;
    logic [31:0] res = '0;
    logic cy = 1'b0;
    bit right = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
    logic sb = val[wd-1];
    for (int i = 0; i < wd; i++) begin
      if (!right) begin
        if (i - k >= 0) res[i] = val[i-k];
        else if (op == 3'd1 && i == k - 1) res[i] = cin;
      end else begin
        if (i + k < wd) res[i] = val[i+k];
        else if (op == 3'd3) res[i] = sb;
        else if (op == 3'd4 && i == wd - k) res[i] = cin;
      end
    end
    if (k != 0) cy = right ? val[k-1] : val[wd-k];
    return {cy, res};
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input logic ec,
                       input logic en, input logic ez);
    n_checks++;
    if (result_o !== er || carry_o !== ec || neg_o !== en || zero_o !== ez || ovf_o !== 1'b0) begin
      n_fails++;
      $display("FAIL %s: got r=%h c=%b n=%b z=%b v=%b expected r=%h c=%b n=%b z=%b v=0",
               tag, result_o, carry_o, neg_o, zero_o, ovf_o, er, ec, en, ez);
    end
  endtask

  task automatic run(input string tag, input logic [2:0] op, input logic [1:0] s,
                     input logic [31:0] val, input logic [7:0] amt, input logic cin);
    logic [32:0] m;
    int wd;
    @(negedge clk);
    op_i = op; size_i = s; value_i = val; amount_i = amt; carry_i = cin;
    m = model(op, s, val, amt, cin);
    wd = width_of(s);
    @(negedge clk);
    check(tag, m[31:0], m[32], m[wd-1], m[31:0] == '0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    op_i = 3'd1; value_i = 32'hFFFF_FFFF; amount_i = 8'd3; carry_i = 1'b1;
    @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_latency();
    @(negedge clk);
    op_i = 3'd0; size_i = 2'd2; value_i = 32'h0000_0001; amount_i = 8'd4; carry_i = 1'b0;
    @(posedge clk); #1;
    op_i = 3'd2; value_i = 32'h8000_0000; amount_i = 8'd31;
    @(negedge clk);
    check("R2 latency first", 32'h10, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 latency second", 32'h1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mask();
    run("R3 8-bit amount 9", 3'd0, 2'd0, 32'h0000_0081, 8'd9, 1'b0);
    check("R3 explicit", 32'h02, 1'b1, 1'b0, 1'b0);
    run("R3 16-bit amount 17", 3'd2, 2'd1, 32'h0000_8001, 8'd17, 1'b0);
    run("R3 32-bit amount 33", 3'd0, 2'd3, 32'h8000_0001, 8'd33, 1'b0);
    run("R3 8-bit amount 8", 3'd2, 2'd0, 32'hABCD_EF5A, 8'd8, 1'b1);
    check("R3 R4 masked to zero", 32'h5A, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_zero_amount();
    for (int op = 0; op < 5; op++) run("R4 zero amount", 3'(op), 2'd1, 32'h1234_F00F, 8'd0, 1'b1);
    check("R4 explicit", 32'h0000_F00F, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_shl();
    run("R5 shl 16", 3'd0, 2'd1, 32'h0000_C001, 8'd1, 1'b1);
    check("R5 explicit", 32'h0000_8002, 1'b1, 1'b1, 1'b0);
    run("R5 shl unused op", 3'd6, 2'd0, 32'h0000_0003, 8'd7, 1'b1);
    check("R5 unused op explicit", 32'h80, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_shlc();
    run("R6 shlc", 3'd1, 2'd0, 32'h0000_0001, 8'd3, 1'b1);
    check("R6 explicit", 32'h0C, 1'b0, 1'b0, 1'b0);
    run("R6 shlc 32 n=1", 3'd1, 2'd2, 32'h8000_0000, 8'd1, 1'b1);
    check("R6 R11 zero clear", 32'h1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_shr();
    run("R7 shr", 3'd2, 2'd2, 32'h8000_0006, 8'd2, 1'b1);
    check("R7 explicit", 32'h2000_0001, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_sar();
    run("R8 sar 8 neg", 3'd3, 2'd0, 32'h0000_0090, 8'd4, 1'b0);
    check("R8 explicit", 32'hF9, 1'b0, 1'b1, 1'b0);
    run("R8 sar 16 pos", 3'd3, 2'd1, 32'h0000_4000, 8'd14, 1'b0);
    check("R8 positive", 32'h1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_shrc();
    run("R9 shrc", 3'd4, 2'd1, 32'h0000_0003, 8'd1, 1'b1);
    check("R9 explicit", 32'h0000_8001, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_flags();
    run("R11 zero result", 3'd2, 2'd0, 32'h0000_0001, 8'd1, 1'b0);
    check("R11 zero explicit", 32'h0, 1'b1, 1'b0, 1'b1);
    run("R11 upper bits", 3'd0, 2'd0, 32'hFFFF_FFFF, 8'd0, 1'b0);
    check("R10 R11 explicit", 32'hFF, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_sweep();
    logic [31:0] pat;
    for (int s = 0; s < 4; s++)
      for (int op = 0; op < 8; op++)
        for (int a = 0; a < 40; a += 3) begin
          pat = 32'h9E37_79B9 * 32'(a + 7 * op + 13 * s) ^ 32'h5A5A_0F0F;
          run("R5 R6 R7 R8 R9 sweep", 3'(op), 2'(s), pat, 8'(a), 1'((a + op) & 1));
        end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latency();
        t_mask();
        t_zero_amount();
        t_shl();
        t_shlc();
        t_shr();
        t_sar();
        t_shrc();
        t_flags();
        t_sweep();
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fails++;
          $display("FAIL watchdog: got hung run expected completion");
        end
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule